// File: doc/BRIEF.md
# Single-Byte I2C Bus Master

This block is an I2C bus master that moves one byte per command. Software programs four registers: a target-address register (7-bit address plus a direction bit), a data register, a timer-period value that sets the SCL rate, and an enable bit. It then writes a command word whose RUN, START and STOP bits select the bus actions. The engine produces the START condition, the address byte, one data byte in either direction and the STOP condition. It samples the acknowledge after each byte and reports the outcome through status bits and a single interrupt source. The interrupt has a mask, a raw and a masked view, and a write-one-to-clear register.

Both bus lines are open-drain. The block drives a line low by raising its output enable and reads SDA back from the wire. An input marks when the block's clock is running. Register accesses are refused until three cycles after that input rises.

SCL timing comes from a prescaler. Each bit period has ten phases: six with SCL low and four with SCL high. Each phase lasts 2·(T+1) system clocks, where T is the timer-period value. A transaction that ends without STOP keeps the bus, holding SCL low. A later command can then send a further byte and release the bus with STOP.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, reads return 0 at offsets 0x00 (target address), 0x04 (command/status), 0x08 (data), 0x10 (mask), 0x14 (raw status), 0x18 (masked status), 0x1C (clear) and 0x20 (config), and 0x01 at 0x0C (timer period). `scl_oe`, `sda_oe` and `irq` are low.
- R2: While `clk_en` is low, and on the first three rising clock edges with `clk_en` high, reads return 0 and writes have no effect. From the fourth edge on, accesses take effect.
- R3: SCL stays low for 12·(T+1) clocks and high for 8·(T+1) clocks, for an SCL period of 20·(T+1) clocks.
- R4: With config bit 0 set, writing 0x07 to the command register from idle sends, MSB first, exactly one START, the target-address byte, the data byte and one STOP. The command bits are bit 0 RUN, bit 1 START and bit 2 STOP. In the target-address register, bits 7:1 are the address and bit 0 is the direction (0 = send). The raw interrupt rises 194·2·(T+1) clocks after the clock edge that accepted the command.
- R5: The status read at 0x04 has these bits:
  - bit 0: busy, from the accepted command until the engine stops or holds.
  - bit 6: bus-busy, from START until STOP.
  - bit 1: error.
  - bit 2: address NACK.
  - bit 3: data NACK.
  After a clean send the status reads 0, and while a START is being issued it reads 0x41.
- R6: A NACK to the address byte sets status bits 2 and 1 and ends with STOP. No data byte is sent.
- R7: A NACK to a sent data byte sets status bits 3 and 1 and ends with STOP.
- R8: With direction bit 1, the block shifts in one byte from the target, answers it with NACK and sends STOP. The byte then reads back at 0x08.
- R9: A command of 0x03 leaves the bus held: SCL low, status 0x40, no STOP. A following command of 0x05 sends the data byte with no new START and then STOP.
- R10: A RUN command is ignored when it has no START and the bus is idle, when the engine is busy, and when config bit 0 is clear.
- R11: Raw status bit 0 is set when a transaction ends, whether by STOP or by hold. Writing 1 to bit 0 at 0x1C clears it, but a set in the same cycle wins. The masked status and `irq` equal raw AND mask bit 0.
- R12: Writes to the raw and masked status registers have no effect, and the clear register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Block clock running; gates register access and engine |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Masked completion interrupt |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
Two actions can meet in one clock edge: the engine setting the raw interrupt as a transaction finishes, and a software write to the clear register. The bench first measures the completion latency against the computed 194·2·(T+1) clocks. It then repeats the same transfer and places a clear write on exactly that edge, expecting the status bit still set afterwards; a later clear must remove it. The transaction checks sweep all timer values 0 to 3 against four data patterns, using a bus-target model on the open-drain lines.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int TPR_W = 7,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in
);
  localparam int CW = TPR_W + 1;
  localparam logic [AW-1:0] A_SADR = AW'(8'h00);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h04);
  localparam logic [AW-1:0] A_DATA = AW'(8'h08);
  localparam logic [AW-1:0] A_TPR  = AW'(8'h0C);
  localparam logic [AW-1:0] A_IMR  = AW'(8'h10);
  localparam logic [AW-1:0] A_RIS  = AW'(8'h14);
  localparam logic [AW-1:0] A_MIS  = AW'(8'h18);
  localparam logic [AW-1:0] A_ICR  = AW'(8'h1C);
  localparam logic [AW-1:0] A_CFG  = AW'(8'h20);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_STOP, S_HOLD} st_t;

  st_t st;
  logic [1:0] en_cnt;
  logic [7:0] sadr_q, data_q, shift;
  logic [TPR_W-1:0] tpr_q;
  logic imr_q, ris, cfg_en;
  logic [CW-1:0] cnt;
  logic [3:0] ph, ph_n, bitc;
  logic is_addr, rx, stop_req, ack_q, adr_nack, dat_nack, scl_q, sda_q;
  logic acc_ok, wr, running, tick, ctrl_go, go_start, go_data;

  assign acc_ok   = clk_en && en_cnt == 2'd3;
  assign wr       = wr_en && acc_ok;
  assign running  = st == S_START || st == S_BIT || st == S_STOP;
  assign tick     = running && cnt >= {tpr_q, 1'b1};
  assign ph_n     = (ph == 4'd9) ? 4'd0 : ph + 4'd1;
  assign ctrl_go  = wr && addr == A_CTRL && wdata[0] && cfg_en;
  assign go_start = ctrl_go && wdata[1] && (st == S_IDLE || st == S_HOLD);
  assign go_data  = ctrl_go && !wdata[1] && st == S_HOLD;
  assign scl_oe   = scl_q;
  assign sda_oe   = sda_q;
  assign irq      = ris && imr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_cnt <= 2'd0;
    else if (!clk_en) en_cnt <= 2'd0;
    else if (en_cnt != 2'd3) en_cnt <= en_cnt + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sadr_q <= '0; data_q <= '0; shift <= '0;
      tpr_q <= TPR_W'(1); imr_q <= 1'b0; ris <= 1'b0; cfg_en <= 1'b0;
      cnt <= '0; ph <= '0; bitc <= '0;
      is_addr <= 1'b0; rx <= 1'b0; stop_req <= 1'b0; ack_q <= 1'b0;
      adr_nack <= 1'b0; dat_nack <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
    end else if (clk_en) begin
      if (wr)
        case (addr)
          A_SADR: sadr_q <= wdata;
          A_DATA: data_q <= wdata;
          A_TPR:  tpr_q  <= wdata[TPR_W-1:0];
          A_IMR:  imr_q  <= wdata[0];
          A_ICR:  if (wdata[0]) ris <= 1'b0;
          A_CFG:  cfg_en <= wdata[0];
          default: ;
        endcase
      if (go_start) begin
        st <= S_START; ph <= (st == S_IDLE) ? 4'd6 : 4'd0; cnt <= '0;
        stop_req <= wdata[2]; rx <= sadr_q[0];
        adr_nack <= 1'b0; dat_nack <= 1'b0;
      end else if (go_data) begin
        st <= S_BIT; ph <= 4'd0; cnt <= '0; bitc <= 4'd8; is_addr <= 1'b0;
        shift <= data_q; stop_req <= wdata[2];
        adr_nack <= 1'b0; dat_nack <= 1'b0;
      end else if (running) begin
        if (!tick) cnt <= cnt + 1'b1;
        else begin
          cnt <= '0;
          ph  <= ph_n;
          case (st)
            S_START: begin
              if (ph_n == 4'd6) scl_q <= 1'b0;
              if (ph_n == 4'd8) sda_q <= 1'b1;
              if (ph == 4'd9) begin
                st <= S_BIT; bitc <= 4'd8; is_addr <= 1'b1;
                shift <= sadr_q; scl_q <= 1'b1;
              end
            end
            S_BIT: begin
              if (ph_n == 4'd1)
                sda_q <= (bitc != 4'd0) && (is_addr || !rx) && !shift[7];
              if (ph_n == 4'd6) scl_q <= 1'b0;
              if (ph_n == 4'd8) begin
                if (bitc != 4'd0) shift <= {shift[6:0], sda_in};
                else ack_q <= sda_in;
              end
              if (ph == 4'd9) begin
                scl_q <= 1'b1;
                if (bitc != 4'd0) bitc <= bitc - 4'd1;
                else if (is_addr) begin
                  if (ack_q) begin adr_nack <= 1'b1; st <= S_STOP; end
                  else begin is_addr <= 1'b0; bitc <= 4'd8; shift <= data_q; end
                end else begin
                  if (rx) data_q <= shift;
                  if (!rx && ack_q) begin dat_nack <= 1'b1; st <= S_STOP; end
                  else if (stop_req) st <= S_STOP;
                  else begin st <= S_HOLD; ris <= 1'b1; end
                end
              end
            end
            S_STOP: begin
              if (ph_n == 4'd1) sda_q <= 1'b1;
              if (ph_n == 4'd6) scl_q <= 1'b0;
              if (ph_n == 4'd8) sda_q <= 1'b0;
              if (ph == 4'd9) begin st <= S_IDLE; ris <= 1'b1; end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (acc_ok)
      case (addr)
        A_SADR: rdata = sadr_q;
        A_CTRL: rdata = {1'b0, st != S_IDLE, 2'b00, dat_nack, adr_nack,
                         adr_nack | dat_nack, running};
        A_DATA: rdata = data_q;
        A_TPR:  rdata = 8'(tpr_q);
        A_IMR:  rdata = {7'd0, imr_q};
        A_RIS:  rdata = {7'd0, ris};
        A_MIS:  rdata = {7'd0, ris & imr_q};
        A_CFG:  rdata = {7'd0, cfg_en};
        default: ;
      endcase
  end

  p_locked_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_ok) |=> ($stable(tpr_q) && $stable(sadr_q)));
  p_idle_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> (!scl_q && !sda_q));
  p_sda_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && $past(st) == S_BIT && sda_q != $past(sda_q)) |-> scl_q);
  p_addr_nack_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adr_nack) |-> st == S_STOP);
  p_data_nack_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_nack) |-> st == S_STOP);
  p_hold_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_HOLD |-> scl_q);
  p_ris_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ris) |-> (st == S_IDLE || st == S_HOLD));
endmodule

// File: tb/test_i2c_cmd_master.sv
module test_i2c_cmd_master;
  localparam logic [5:0] A_SADR = 6'h00, A_CTRL = 6'h04, A_DATA = 6'h08,
    A_TPR = 6'h0C, A_IMR = 6'h10, A_RIS = 6'h14, A_MIS = 6'h18,
    A_ICR = 6'h1C, A_CFG = 6'h20;
  localparam logic [6:0] SLV = 7'h3B;

  logic clk = 0, rst_n = 0, clk_en = 0, wr_en = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  wire [7:0] rdata;
  wire irq, scl_oe, sda_oe;
  logic s_drv = 0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || s_drv);

  i2c_cmd_master i_i2c_cmd_master (.clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit ended = 0;

  // bus target model
  logic pscl = 1, psda = 1, first = 0, rdmode = 0, acked = 0, rdph = 0, mack = 0;
  logic [7:0] sh = 0, got_addr = 0, got_data = 0, rd_byte = 0;
  int cyc = 0, n = 0, nbytes = 0, n_start = 0, n_stop = 0, t_r1 = 0, t_r2 = 0, t_f = 0;
  bit ack_data_en = 1, s_clr = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    pscl <= scl_line;
    psda <= sda_line;
    if (s_clr) begin nbytes <= 0; n_start <= 0; n_stop <= 0; end
    else if (pscl && scl_line && psda && !sda_line) begin
      n_start <= n_start + 1; n <= 0; first <= 1; rdph <= 0; s_drv <= 0;
    end else if (pscl && scl_line && !psda && sda_line) begin
      n_stop <= n_stop + 1; rdph <= 0; s_drv <= 0;
    end else if (!pscl && scl_line) begin
      n <= n + 1;
      if (n < 8) sh <= {sh[6:0], sda_line};
      if (n == 7) begin
        nbytes <= nbytes + 1;
        if (first) got_addr <= {sh[6:0], sda_line};
        else got_data <= {sh[6:0], sda_line};
      end
      if (n == 8) mack <= !sda_line;
      if (first && n == 0) t_r1 <= cyc;
      if (first && n == 1) t_r2 <= cyc;
    end else if (pscl && !scl_line) begin
      if (first && n == 1) t_f <= cyc;
      if (n == 8) begin
        if (first) begin
          acked <= (sh[7:1] == SLV); rdmode <= sh[0]; s_drv <= (sh[7:1] == SLV);
        end else if (!rdph) s_drv <= ack_data_en;
        else s_drv <= 0;
      end else if (n == 9) begin
        n <= 0; first <= 0;
        if (first && rdmode && acked) begin rdph <= 1; s_drv <= !rd_byte[7]; end
        else if (rdph && mack) s_drv <= !rd_byte[7];
        else begin rdph <= 0; s_drv <= 0; end
      end else if (rdph && n >= 1 && n <= 7) s_drv <= !rd_byte[7-n];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic sclr;
    @(negedge clk); s_clr = 1;
    @(negedge clk); s_clr = 0;
  endtask

  task automatic wait_irq(output int cnt);
    cnt = 0;
    while (!irq) begin @(negedge clk); cnt++; end
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int cyc_n, p;
    logic [7:0] pats[4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(A_TPR, v); chk("R2 read while clock off", v, 0);
    @(negedge clk); clk_en = 1; addr = A_TPR; wdata = 8'h05; wr_en = 1;
    repeat (3) @(negedge clk); wr_en = 0;
    rd(A_TPR, v);  chk("R2/R1 timer after locked writes", v, 1);
    rd(A_SADR, v); chk("R1 sadr", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_DATA, v); chk("R1 data", v, 0);
    rd(A_IMR, v);  chk("R1 imr", v, 0);
    rd(A_RIS, v);  chk("R1 ris", v, 0);
    rd(A_MIS, v);  chk("R1 mis", v, 0);
    rd(A_CFG, v);  chk("R1 cfg", v, 0);
    chk("R1 lines/irq", {scl_oe, sda_oe, irq}, 0);
    wr(A_TPR, 8'h05); rd(A_TPR, v); chk("R2 write accepted", v, 5);
    wr(A_CFG, 1); wr(A_IMR, 1);

    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 4; k++) begin
        p = 2 * (t + 1);
        wr(A_TPR, 8'(t)); wr(A_ICR, 1); sclr();
        wr(A_DATA, pats[k]); wr(A_SADR, {SLV, 1'b0});
        wr(A_CTRL, 8'h07); wait_irq(cyc_n);
        chk("R4 completion cycles", cyc_n, 194 * p);
        repeat (4) @(negedge clk);
        chk("R4 address byte", got_addr, {SLV, 1'b0});
        chk("R4 data byte", got_data, pats[k]);
        chk("R4 byte count", nbytes, 2);
        chk("R4 start/stop count", n_start * 16 + n_stop, 17);
        chk("R3 scl period", t_r2 - t_r1, 10 * p);
        chk("R3 scl low", t_r2 - t_f, 6 * p);
        rd(A_CTRL, v); chk("R5 status after send", v, 0);
      end

    wr(A_TPR, 1);
    // R6 address not acknowledged
    wr(A_ICR, 1); sclr(); wr(A_SADR, 8'h20); wr(A_CTRL, 8'h07); wait_irq(cyc_n);
    repeat (4) @(negedge clk);
    rd(A_CTRL, v); chk("R6 status", v, 8'h06);
    chk("R6 only address byte", nbytes, 1);
    chk("R6 stop sent", n_stop, 1);
    // R7 data not acknowledged
    ack_data_en = 0;
    wr(A_ICR, 1); sclr(); wr(A_SADR, {SLV, 1'b0}); wr(A_CTRL, 8'h07); wait_irq(cyc_n);
    repeat (4) @(negedge clk);
    ack_data_en = 1;
    rd(A_CTRL, v); chk("R7 status", v, 8'h0A);
    chk("R7 stop sent", n_stop, 1);
    // R8 receive
    rd_byte = 8'hC6;
    wr(A_ICR, 1); sclr(); wr(A_SADR, {SLV, 1'b1}); wr(A_CTRL, 8'h07); wait_irq(cyc_n);
    repeat (4) @(negedge clk);
    rd(A_DATA, v); chk("R8 received byte", v, 8'hC6);
    rd(A_CTRL, v); chk("R8 status", v, 0);
    chk("R8 stop sent", n_stop, 1);
    // R9 hold then continue
    wr(A_ICR, 1); sclr(); wr(A_SADR, {SLV, 1'b0}); wr(A_DATA, 8'h11);
    wr(A_CTRL, 8'h03); wait_irq(cyc_n);
    repeat (20) @(negedge clk);
    rd(A_CTRL, v); chk("R9 held status", v, 8'h40);
    chk("R9 scl held low", scl_oe, 1);
    chk("R9 no stop while held", n_stop, 0);
    wr(A_ICR, 1); wr(A_DATA, 8'h22); wr(A_CTRL, 8'h05); wait_irq(cyc_n);
    repeat (4) @(negedge clk);
    chk("R9 continued byte", got_data, 8'h22);
    chk("R9 single start", n_start, 1);
    chk("R9 stop after continue", n_stop, 1);
    chk("R9 bytes", nbytes, 3);
    rd(A_CTRL, v); chk("R9 status end", v, 0);
    // R10 ignored commands
    wr(A_ICR, 1); sclr(); wr(A_CTRL, 8'h01); repeat (20) @(negedge clk);
    rd(A_CTRL, v); chk("R10 run without start idle", v, 0);
    chk("R10 no start issued", n_start, 0);
    wr(A_CTRL, 8'h07); rd(A_CTRL, v); chk("R5 status while starting", v, 8'h41);
    wr(A_CTRL, 8'h07); wait_irq(cyc_n); repeat (4) @(negedge clk);
    chk("R10 busy command ignored", n_start * 16 + n_stop, 17);
    wr(A_ICR, 1); sclr(); wr(A_CFG, 0); wr(A_CTRL, 8'h07); repeat (20) @(negedge clk);
    rd(A_CTRL, v); chk("R10 disabled status", v, 0);
    chk("R10 disabled no start", n_start, 0);
    wr(A_CFG, 1);
    // R11 mask and clear
    wr(A_IMR, 0); wr(A_ICR, 1); wr(A_CTRL, 8'h07);
    v = 8'h40;
    while (v != 0) rd(A_CTRL, v);
    chk("R11 irq masked", irq, 0);
    rd(A_RIS, v); chk("R11 raw set", v, 1);
    rd(A_MIS, v); chk("R11 masked zero", v, 0);
    wr(A_IMR, 1); #1 chk("R11 irq unmasked", irq, 1);
    rd(A_MIS, v); chk("R11 masked set", v, 1);
    wr(A_ICR, 1); rd(A_RIS, v); chk("R11 clear", v, 0);
    chk("R11 irq after clear", irq, 0);
    // R11 coincident set and clear (T=1, P=4)
    wr(A_CTRL, 8'h07);
    repeat (194 * 4 - 1) @(negedge clk);
    addr = A_ICR; wdata = 8'h01; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(A_RIS, v); chk("R11 set wins over clear", v, 1);
    wr(A_ICR, 1); rd(A_RIS, v); chk("R11 later clear", v, 0);
    // R12 read-only and write-only
    wr(A_RIS, 8'hFF); rd(A_RIS, v); chk("R12 raw read-only", v, 0);
    wr(A_MIS, 8'hFF); rd(A_MIS, v); chk("R12 masked read-only", v, 0);
    rd(A_ICR, v); chk("R12 clear reads zero", v, 0);
    finish_run();
  end
endmodule